// File: doc/BRIEF.md
# Vectored two-level interrupt controller

This block gathers 96 level-sensitive interrupt lines, arranged as three banks of 32, and turns them into two processor request lines: a normal request and a fast request. Each line's current level is mirrored into a read-only pending bit. A per-line mask bit suppresses the line, and a per-line select bit additionally routes it to the fast request. A priority encoder picks the lowest-numbered line that is pending and unmasked, and presents its number times four as a vector that software reads to dispatch the handler.

Software reaches the block through a simple synchronous register port with word addresses. The port holds a vector word, a base-address word whose two low bits always read zero, two plain storage words (protect and NMI control), and five banked groups: pending, fast-pending, select, enable and mask. Enable bits are stored and read back but do not gate the requests. The fast-pending bits are write-one-to-clear and nothing inside the block sets them.

Top module: `vic_ctrl`

## Requirements
- R1: Source n maps to bank n/32, bit n%32. Each source level is sampled on every clock edge into its pending bit. A read of word 0x10 + 4*b returns pending bank b.
- R2: `irq_o` is high exactly when some source has its pending bit set and its mask bit clear. It follows a change of `src_i` one clock edge later.
- R3: `fiq_o` is high exactly when some source has its select bit set, its pending bit set and its mask bit clear.
- R4: Word 0x00 reads four times the index of the lowest-numbered source that is pending and unmasked. It reads 0 when no source is active.
- R5: Writes to the pending words 0x10–0x18 have no effect.
- R6: The fast-pending words 0x20–0x28 clear each bit written as one. They reset to zero and the block never sets them.
- R7: A write to 0x04 stores the data with bits [1:0] forced to zero.
- R8: Words 0x08 and 0x0C, and the select (0x30–0x38), enable (0x40–0x48) and mask (0x50–0x58) banks, read back what was written. Enable bits do not affect `irq_o`, `fiq_o` or the vector.
- R9: Read data appears on `rdata_o` in the cycle after a read request and is 0 in every other cycle. A write takes effect at the clock edge that samples it.
- R10: Reads of unmapped words return 0 and writes to them change nothing. Unmapped words are bank index 3 of any bank group, offsets 0x60 and above, and any address with bits [1:0] not zero.
- R11: Asserting `rst_ni` low asynchronously clears every register, the pending bits, `rdata_o`, `irq_o` and `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 96 | Interrupt source levels |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Byte address of the register word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A wrong pending, mask or select bit shows on `irq_o` or `fiq_o` at the next sample, because the bench compares both lines against its model on every clock. A stale or wrong bit that does not change the OR terms still shows in the vector word or in the bank read-back, one cycle after the read is issued. Ordering faults in the priority encoder appear only when several sources are active together, so the bench drives multi-source patterns across bank boundaries and masks the winner to expose the next one. Decode faults show as nonzero reads from unmapped words or as a group changing after a write aimed elsewhere.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned BANK_W = 32;
  localparam int unsigned DATA_W = 32;
  // word groups, selected by addr[9:4]
  localparam int unsigned GRP_CTRL  = 0;
  localparam int unsigned GRP_PEND  = 1;
  localparam int unsigned GRP_FPEND = 2;
  localparam int unsigned GRP_SEL   = 3;
  localparam int unsigned GRP_EN    = 4;
  localparam int unsigned GRP_MASK  = 5;
  // control words, selected by addr[3:2]
  localparam int unsigned CW_VEC  = 0;
  localparam int unsigned CW_BASE = 1;
  localparam int unsigned CW_PROT = 2;
  localparam int unsigned CW_NMI  = 3;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 10,
  localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int unsigned GRP_W    = ADDR_W - 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               wr_i,
  input  logic [GRP_W-1:0]   grp_i,
  input  logic [1:0]         widx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] fpend_o,
  output logic [NUM_SRC-1:0] sel_o,
  output logic [NUM_SRC-1:0] en_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [DATA_W-1:0]  base_o,
  output logic [DATA_W-1:0]  prot_o,
  output logic [DATA_W-1:0]  nmi_o
);
  logic ctrl_wr;
  assign ctrl_wr = wr_i && (grp_i == GRP_W'(GRP_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= src_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      prot_o <= '0;
      nmi_o  <= '0;
    end else if (ctrl_wr) begin
      case (widx_i)
        2'(CW_BASE): base_o <= {wdata_i[DATA_W-1:2], 2'b00};
        2'(CW_PROT): prot_o <= wdata_i;
        2'(CW_NMI):  nmi_o  <= wdata_i;
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_i && (widx_i == 2'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fpend_o[b*BANK_W +: BANK_W] <= '0;
        sel_o[b*BANK_W +: BANK_W]   <= '0;
        en_o[b*BANK_W +: BANK_W]    <= '0;
        mask_o[b*BANK_W +: BANK_W]  <= '0;
      end else if (hit) begin
        if (grp_i == GRP_W'(GRP_FPEND))
          fpend_o[b*BANK_W +: BANK_W] <= fpend_o[b*BANK_W +: BANK_W] & ~wdata_i;
        if (grp_i == GRP_W'(GRP_SEL))  sel_o[b*BANK_W +: BANK_W]  <= wdata_i;
        if (grp_i == GRP_W'(GRP_EN))   en_o[b*BANK_W +: BANK_W]   <= wdata_i;
        if (grp_i == GRP_W'(GRP_MASK)) mask_o[b*BANK_W +: BANK_W] <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/vic_prio.sv
module vic_prio
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 96
) (
  input  logic [NUM_SRC-1:0] act_i,
  output logic [DATA_W-1:0]  vec_o
);
  // scan from the top so the lowest active index is written last
  always_comb begin
    vec_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) vec_o = DATA_W'(i) << 2;
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 10,
  localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W,
  localparam int unsigned GRP_W    = ADDR_W - 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [NUM_SRC-1:0] pend, fpend, sel, en, mask, act;
  logic [DATA_W-1:0]  base, prot, nmi, vec, rd_mux;
  logic [GRP_W-1:0]   grp;
  logic [1:0]         widx;
  logic               aligned, bank_ok;

  assign grp     = addr_i[ADDR_W-1:4];
  assign widx    = addr_i[3:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign bank_ok = (32'(widx) < NUM_BANKS);

  vic_regs #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_i   (src_i),
    .wr_i    (req_i && we_i && aligned),
    .grp_i   (grp),
    .widx_i  (widx),
    .wdata_i (wdata_i),
    .pend_o  (pend),
    .fpend_o (fpend),
    .sel_o   (sel),
    .en_o    (en),
    .mask_o  (mask),
    .base_o  (base),
    .prot_o  (prot),
    .nmi_o   (nmi)
  );

  assign act   = pend & ~mask;
  assign irq_o = |act;
  assign fiq_o = |(act & sel);

  vic_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .act_i (act),
    .vec_o (vec)
  );

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (grp == GRP_W'(GRP_CTRL)) begin
        case (widx)
          2'(CW_VEC):  rd_mux = vec;
          2'(CW_BASE): rd_mux = base;
          2'(CW_PROT): rd_mux = prot;
          default:     rd_mux = nmi;
        endcase
      end else if (bank_ok) begin
        case (grp)
          GRP_W'(GRP_PEND):  rd_mux = pend[32'(widx)*BANK_W +: BANK_W];
          GRP_W'(GRP_FPEND): rd_mux = fpend[32'(widx)*BANK_W +: BANK_W];
          GRP_W'(GRP_SEL):   rd_mux = sel[32'(widx)*BANK_W +: BANK_W];
          GRP_W'(GRP_EN):    rd_mux = en[32'(widx)*BANK_W +: BANK_W];
          GRP_W'(GRP_MASK):  rd_mux = mask[32'(widx)*BANK_W +: BANK_W];
          default:           rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_o <= '0;
    else if (req_i && !we_i)    rdata_o <= rd_mux;
    else                        rdata_o <= '0;
  end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int unsigned NUM_SRC = 96
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_i,
  input logic [NUM_SRC-1:0] pend_i,
  input logic [NUM_SRC-1:0] fpend_i,
  input logic [31:0]        vec_i,
  input logic [31:0]        base_i,
  input logic               irq_i,
  input logic               fiq_i
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  a_r1_pend_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (pend_i == $past(src_i)));

  a_r3_fiq_implies_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_i |-> irq_i);

  a_r4_vec_implies_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_i != 32'd0) |-> irq_i);

  a_r4_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_i[1:0] == 2'b00);

  a_r6_fpend_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> ((fpend_i & ~$past(fpend_i)) == '0));

  a_r7_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_i[1:0] == 2'b00);
endmodule

bind vic_ctrl vic_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .pend_i  (pend),
  .fpend_i (fpend),
  .vec_i   (vec),
  .base_i  (base),
  .irq_i   (irq_o),
  .fiq_i   (fiq_o)
);

// File: tb/tb_vic_ctrl.sv
module tb_vic_ctrl;
  localparam int PERIOD = 10;
  localparam int NSRC   = 96;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [95:0] src_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [9:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, fiq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  vic_ctrl dut (.*);

  always #(PERIOD/2) clk_i = ~clk_i;

  // reference model, one entry per source
  bit m_pend[NSRC], m_fpend[NSRC], m_sel[NSRC], m_en[NSRC], m_mask[NSRC];
  logic [31:0] m_base, m_prot, m_nmi;

  task automatic m_reset();
    for (int n = 0; n < NSRC; n++) begin
      m_pend[n] = 0; m_fpend[n] = 0; m_sel[n] = 0; m_en[n] = 0; m_mask[n] = 0;
    end
    m_base = 0; m_prot = 0; m_nmi = 0;
  endtask

  function automatic logic [31:0] m_vec();
    for (int n = 0; n < NSRC; n++) if (m_pend[n] && !m_mask[n]) return 32'(n * 4);
    return 0;
  endfunction

  function automatic bit m_irq();
    for (int n = 0; n < NSRC; n++) if (m_pend[n] && !m_mask[n]) return 1;
    return 0;
  endfunction

  function automatic bit m_fiq();
    for (int n = 0; n < NSRC; n++) if (m_sel[n] && m_pend[n] && !m_mask[n]) return 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_read(logic [9:0] a);
    int g = int'(a[9:4]);
    int w = int'(a[3:2]);
    logic [31:0] r = 0;
    if (a[1:0] != 0) return 0;
    if (g == 0) begin
      case (w)
        0: r = m_vec();
        1: r = m_base;
        2: r = m_prot;
        default: r = m_nmi;
      endcase
      return r;
    end
    if (w > 2 || g > 5) return 0;
    for (int k = 0; k < 32; k++) begin
      case (g)
        1: r[k] = m_pend[w*32+k];
        2: r[k] = m_fpend[w*32+k];
        3: r[k] = m_sel[w*32+k];
        4: r[k] = m_en[w*32+k];
        default: r[k] = m_mask[w*32+k];
      endcase
    end
    return r;
  endfunction

  task automatic m_write(logic [9:0] a, logic [31:0] d);
    int g = int'(a[9:4]);
    int w = int'(a[3:2]);
    if (a[1:0] != 0) return;
    if (g == 0) begin
      if (w == 1) m_base = d & ~32'h3;
      if (w == 2) m_prot = d;
      if (w == 3) m_nmi = d;
      return;
    end
    if (w > 2) return;
    for (int k = 0; k < 32; k++) begin
      case (g)
        2: if (d[k]) m_fpend[w*32+k] = 0;
        3: m_sel[w*32+k] = d[k];
        4: m_en[w*32+k] = d[k];
        5: m_mask[w*32+k] = d[k];
        default: ;
      endcase
    end
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, compare at next negedge
  task automatic cyc(bit rd, bit wr, logic [9:0] a, logic [31:0] d, string tag);
    logic [31:0] exp_rd;
    req_i = rd | wr; we_i = wr; addr_i = a; wdata_i = d;
    exp_rd = rd ? m_read(a) : 32'h0;
    if (wr) m_write(a, d);
    for (int n = 0; n < NSRC; n++) m_pend[n] = src_i[n];
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 0; we_i = 0;
    check({tag, " rdata (R9)"}, rdata_o, exp_rd);
    check("R2 irq_o", 32'(irq_o), 32'(m_irq()));
    check("R3 fiq_o", 32'(fiq_o), 32'(m_fiq()));
  endtask

  task automatic rd(logic [9:0] a, string tag); cyc(1, 0, a, 0, tag); endtask
  task automatic wr(logic [9:0] a, logic [31:0] d, string tag); cyc(0, 1, a, d, tag); endtask
  task automatic idle(string tag); cyc(0, 0, 0, 0, tag); endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check("R11 rdata at reset", rdata_o, 0);
    check("R11 irq at reset", 32'(irq_o), 0);
    check("R11 fiq at reset", 32'(fiq_o), 0);
    rst_ni = 1;
    @(negedge clk_i);
    rd(10'h00, "R11 vector"); rd(10'h04, "R11 base"); rd(10'h54, "R11 mask");

    // R1/R2/R4: single source in bank 1
    src_i[40] = 1;
    idle("R2 idle");
    rd(10'h00, "R4 vector src40");
    rd(10'h14, "R1 pend bank1");
    idle("R9 no read gives zero");
    // lowest wins across banks
    src_i[70] = 1; src_i[5] = 1;
    idle("R4 settle");
    rd(10'h00, "R4 lowest of 5/40/70");
    rd(10'h18, "R1 pend bank2");
    src_i = '0; src_i[0] = 1;
    idle("R4 settle");
    rd(10'h00, "R4 source 0 vector zero");
    src_i = '0; src_i[5] = 1; src_i[70] = 1;
    idle("R4 settle");

    // R8: mask reveals next source, select routes to fiq
    wr(10'h50, 32'h0000_0020, "R8 mask src5");
    rd(10'h00, "R4 vector after mask");
    rd(10'h50, "R8 mask readback");
    wr(10'h38, 32'h0000_0040, "R3 select src70");
    rd(10'h38, "R8 select readback");
    wr(10'h58, 32'h0000_0040, "R3 mask src70");
    rd(10'h00, "R4 all masked vector zero");
    wr(10'h58, 32'h0, "R3 unmask src70");

    // R5: pending write ignored
    wr(10'h10, 32'hFFFF_FFFF, "R5 write pend");
    rd(10'h10, "R5 pend unchanged");
    // R6: fast pending write-one-to-clear, stays zero
    wr(10'h24, 32'hFFFF_FFFF, "R6 w1c");
    rd(10'h24, "R6 fpend reads zero");
    // R7: base low bits forced
    wr(10'h04, 32'h1234_5677, "R7 base write");
    rd(10'h04, "R7 base readback");
    // R8: plain storage, enable does not gate
    wr(10'h08, 32'hA5A5_0001, "R8 protect");
    wr(10'h0C, 32'h0000_0003, "R8 nmi");
    rd(10'h08, "R8 protect readback");
    rd(10'h0C, "R8 nmi readback");
    wr(10'h48, 32'hFFFF_FFFF, "R8 enable set");
    rd(10'h48, "R8 enable readback");
    wr(10'h48, 32'h0, "R8 enable clear, irq unchanged");
    rd(10'h00, "R8 vector independent of enable");

    // R10: unmapped
    rd(10'h1C, "R10 bank3 pend");
    rd(10'h60, "R10 offset 0x60");
    rd(10'h3FC, "R10 top offset");
    rd(10'h06, "R10 misaligned read");
    wr(10'h3C, 32'hFFFF_FFFF, "R10 write bank3 select");
    wr(10'h32, 32'hFFFF_FFFF, "R10 misaligned write");
    wr(10'h70, 32'hFFFF_FFFF, "R10 write 0x70");
    rd(10'h30, "R10 select bank0 unchanged");
    rd(10'h34, "R10 select bank1 unchanged");
    rd(10'h38, "R10 select bank2 unchanged");

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      logic [9:0] a;
      int pick = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) src_i = {$urandom(), $urandom(), $urandom()} & {3{$urandom()}};
      a = {2'b00, 4'($urandom_range(0, 6)), 2'($urandom_range(0, 3)), 2'b00};
      if (pick < 4) rd(a, "R1 R4 R8 mixed read");
      else if (pick < 7) wr(a, $urandom() & $urandom(), "R5 R6 R8 mixed write");
      else idle("R2 R3 mixed idle");
    end

    // R11: reset mid-run
    wr(10'h08, 32'hDEAD_BEEC, "R11 pre-reset protect");
    #(PERIOD/4) rst_ni = 0;
    #(PERIOD/4);
    check("R11 irq async clear", 32'(irq_o), 0);
    check("R11 fiq async clear", 32'(fiq_o), 0);
    check("R11 rdata async clear", rdata_o, 0);
    m_reset();
    src_i = '0;
    @(negedge clk_i);
    rst_ni = 1;
    rd(10'h08, "R11 protect cleared");
    rd(10'h50, "R11 mask cleared");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule